// File: doc/BRIEF.md
# Floating-Point Register Stack

This block holds eight 80-bit operand registers arranged as a circular stack. A three-bit top pointer names the current top entry, ST(0). ST(i) is the entry i places further in. Each slot carries a tag bit that says whether it holds a live value. Callers issue one stack operation per cycle over a valid/ready handshake:

- Push places a new value on top.
- Store returns the top value, and the store-pop variant also removes it.
- Read returns any ST(i) without changing the stack.
- Arithmetic issue hands ST(0) and ST(1) to an external arithmetic unit.

While an arithmetic operation is outstanding, the block presents both operands and holds off further operations. When the external unit answers, both operands leave the stack and the result becomes the new top, so the depth drops by one. Illegal accesses are refused, leave the stack as it was, and raise a one-cycle flag:

- A push into a slot that is already live raises the overflow flag.
- A pop or read of an empty slot raises the underflow flag.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset, top_ptr is 0, every slot is empty, op_ready is 1, and rd_valid, overflow, underflow and alu_req_valid are 0.
- R2: A push (op_code 1) into an empty slot writes push_data at physical index (top_ptr-1) mod 8 and moves top_ptr there, visible one cycle after acceptance.
- R3: A push whose target slot is already live raises overflow for one cycle. It changes neither top_ptr nor any entry.
- R4: A read (op_code 5) returns the entry at physical index (top_ptr+op_index) mod 8 on rd_data with rd_valid one cycle after acceptance, and does not change the stack.
- R5: A store (op_code 2) returns ST(0) on rd_data with rd_valid one cycle later and leaves top_ptr unchanged.
- R6: A store-pop (op_code 3) returns ST(0), marks that slot empty and advances top_ptr by one modulo 8.
- R7: An arithmetic issue (op_code 4) with ST(0) and ST(1) both live raises alu_req_valid from the next cycle, with alu_opa=ST(0) and alu_opb=ST(1). op_ready stays 0 until the result is taken.
- R8: When alu_res_valid is sampled high while a request is outstanding, the result replaces ST(1), the old ST(0) slot becomes empty, top_ptr advances by one, and alu_req_valid falls.
- R9: A store, store-pop or read of an empty slot, or an arithmetic issue with fewer than two live top entries, raises underflow for one cycle. In that case rd_valid stays 0, no request is issued, and the stack is unchanged.
- R10: op_valid is ignored while an arithmetic request is outstanding.
- R11: top_ptr wraps modulo 8, so after eight pushes from reset it is 0 again and the stack pops back in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A stack operation is offered |
| op_code | input | 3 | 0 none, 1 push, 2 store, 3 store-pop, 4 arithmetic issue, 5 read ST(i) |
| op_index | input | 3 | Stack-relative position i for a read |
| push_data | input | 80 | Value to push |
| op_ready | output | 1 | An operation is accepted this cycle if offered |
| rd_valid | output | 1 | rd_data holds a store or read result |
| rd_data | output | 80 | Value returned by store or read |
| overflow | output | 1 | One-cycle pulse: push refused, slot already live |
| underflow | output | 1 | One-cycle pulse: access to an empty slot refused |
| top_ptr | output | 3 | Physical index of ST(0) |
| alu_req_valid | output | 1 | Operands presented to the arithmetic unit |
| alu_opa | output | 80 | ST(0) operand |
| alu_opb | output | 80 | ST(1) operand |
| alu_res_valid | input | 1 | Arithmetic result offered |
| alu_res_data | input | 80 | Arithmetic result |

## Verification
The assertions check the following on every cycle:

- A refused push leaves the pointer in place.
- A pending request freezes the pointer until a result arrives.
- A completion moves the pointer by exactly one.
- A refused store reports underflow without data.
- The storage never writes and clears the same slot at once.

Only the bench scenarios can show the following:

- Values really come back in last-in, first-out order.
- ST(i) resolves to the right entry.
- Operands reach the arithmetic port in the right order.
- An overflowing push leaves old contents intact after a wrap.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_PUSH      = 3'd1,
        OP_STORE     = 3'd2,
        OP_STORE_POP = 3'd3,
        OP_ARITH     = 3'd4,
        OP_READ      = 3'd5
    } stk_op_e;
endpackage

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
    parameter int WIDTH = 80,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             clr_en,
    input  logic [PW-1:0]    clr_idx,
    input  logic [PW-1:0]    idx_a,
    input  logic [PW-1:0]    idx_b,
    input  logic [PW-1:0]    idx_c,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b,
    output logic [WIDTH-1:0] rdata_c,
    output logic [DEPTH-1:0] tags
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] ent;
        logic [DEPTH-1:0]            tag;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr_en) begin
            rf_d.ent[wr_idx] = wr_data;
            rf_d.tag[wr_idx] = 1'b1;
        end
        if (clr_en) begin
            rf_d.tag[clr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rdata_a = rf_q.ent[idx_a];
    assign rdata_b = rf_q.ent[idx_b];
    assign rdata_c = rf_q.ent[idx_c];
    assign tags    = rf_q.tag;

    // R8: completion writes one slot and frees another, never the same one
    a_r8_wr_clr_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr_en) |-> (wr_idx != clr_idx));

    // R6: a cleared slot reads back empty
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !tags[$past(clr_idx)]);

    // R2: a written slot becomes live
    a_r2_write_sets_tag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tags[$past(wr_idx)]);
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
#(
    parameter int WIDTH = 80,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [PW-1:0]    op_index,
    input  logic [WIDTH-1:0] push_data,
    input  logic             alu_res_valid,
    input  logic [WIDTH-1:0] alu_res_data,
    input  logic [DEPTH-1:0] tags,
    input  logic [WIDTH-1:0] rdata_c,
    output logic             wr_en,
    output logic [PW-1:0]    wr_idx,
    output logic [WIDTH-1:0] wr_data,
    output logic             clr_en,
    output logic [PW-1:0]    clr_idx,
    output logic [PW-1:0]    idx_a,
    output logic [PW-1:0]    idx_b,
    output logic [PW-1:0]    idx_c,
    output logic             op_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic             overflow,
    output logic             underflow,
    output logic [PW-1:0]    top_ptr,
    output logic             alu_req_valid
);
    typedef struct packed {
        logic             busy;
        logic [PW-1:0]    top;
        logic             rd_valid;
        logic [WIDTH-1:0] rd_data;
        logic             ovf;
        logic             unf;
    } ctl_t;

    ctl_t    ctl_d, ctl_q;
    stk_op_e op;
    logic [PW-1:0] top_m1, top_p1;
    logic          accept;

    assign op     = stk_op_e'(op_code);
    assign top_m1 = ctl_q.top - 1'b1;
    assign top_p1 = ctl_q.top + 1'b1;
    assign accept = op_valid && !ctl_q.busy;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        ctl_d.ovf      = 1'b0;
        ctl_d.unf      = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = top_m1;
        wr_data = push_data;
        clr_en  = 1'b0;
        clr_idx = ctl_q.top;
        idx_a   = ctl_q.top;
        idx_b   = top_p1;
        idx_c   = (op == OP_READ) ? (ctl_q.top + op_index) : ctl_q.top;

        if (ctl_q.busy) begin
            if (alu_res_valid) begin
                wr_en      = 1'b1;
                wr_idx     = top_p1;
                wr_data    = alu_res_data;
                clr_en     = 1'b1;
                clr_idx    = ctl_q.top;
                ctl_d.top  = top_p1;
                ctl_d.busy = 1'b0;
            end
        end else if (accept) begin
            unique case (op)
                OP_PUSH: begin
                    if (tags[top_m1]) begin
                        ctl_d.ovf = 1'b1;
                    end else begin
                        wr_en     = 1'b1;
                        ctl_d.top = top_m1;
                    end
                end
                OP_STORE, OP_STORE_POP: begin
                    if (!tags[ctl_q.top]) begin
                        ctl_d.unf = 1'b1;
                    end else begin
                        ctl_d.rd_valid = 1'b1;
                        ctl_d.rd_data  = rdata_c;
                        if (op == OP_STORE_POP) begin
                            clr_en    = 1'b1;
                            ctl_d.top = top_p1;
                        end
                    end
                end
                OP_READ: begin
                    if (!tags[idx_c]) begin
                        ctl_d.unf = 1'b1;
                    end else begin
                        ctl_d.rd_valid = 1'b1;
                        ctl_d.rd_data  = rdata_c;
                    end
                end
                OP_ARITH: begin
                    if (!(tags[ctl_q.top] && tags[top_p1])) begin
                        ctl_d.unf = 1'b1;
                    end else begin
                        ctl_d.busy = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign op_ready      = !ctl_q.busy;
    assign rd_valid      = ctl_q.rd_valid;
    assign rd_data       = ctl_q.rd_data;
    assign overflow      = ctl_q.ovf;
    assign underflow     = ctl_q.unf;
    assign top_ptr       = ctl_q.top;
    assign alu_req_valid = ctl_q.busy;

    // R3: a refused push moves nothing and flags overflow
    a_r3_no_overflow_move: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_PUSH && tags[top_m1]) |=> ($stable(top_ptr) && overflow));

    // R10: while waiting for a result the pointer is frozen
    a_r10_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_req_valid && !alu_res_valid) |=> ($stable(top_ptr) && alu_req_valid));

    // R8: completion pops one net entry and ends the request
    a_r8_complete_step: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_req_valid && alu_res_valid) |=>
            (top_ptr == $past(top_ptr) + 1'b1 && !alu_req_valid));

    // R9: a store from an empty top reports underflow without data
    a_r9_store_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_STORE || op == OP_STORE_POP) && !tags[top_ptr])
            |=> (underflow && !rd_valid && $stable(top_ptr)));

    // R1: flags are never raised together
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow) && !(rd_valid && underflow));
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack #(
    parameter int WIDTH = 80,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [PW-1:0]    op_index,
    input  logic [WIDTH-1:0] push_data,
    output logic             op_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic             overflow,
    output logic             underflow,
    output logic [PW-1:0]    top_ptr,
    output logic             alu_req_valid,
    output logic [WIDTH-1:0] alu_opa,
    output logic [WIDTH-1:0] alu_opb,
    input  logic             alu_res_valid,
    input  logic [WIDTH-1:0] alu_res_data
);
    logic             wr_en, clr_en;
    logic [PW-1:0]    wr_idx, clr_idx, idx_a, idx_b, idx_c;
    logic [WIDTH-1:0] wr_data, rdata_c;
    logic [DEPTH-1:0] tags;

    fpstk_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .idx_a   (idx_a),
        .idx_b   (idx_b),
        .idx_c   (idx_c),
        .rdata_a (alu_opa),
        .rdata_b (alu_opb),
        .rdata_c (rdata_c),
        .tags    (tags)
    );

    fpstk_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_code       (op_code),
        .op_index      (op_index),
        .push_data     (push_data),
        .alu_res_valid (alu_res_valid),
        .alu_res_data  (alu_res_data),
        .tags          (tags),
        .rdata_c       (rdata_c),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_data),
        .clr_en        (clr_en),
        .clr_idx       (clr_idx),
        .idx_a         (idx_a),
        .idx_b         (idx_b),
        .idx_c         (idx_c),
        .op_ready      (op_ready),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .overflow      (overflow),
        .underflow     (underflow),
        .top_ptr       (top_ptr),
        .alu_req_valid (alu_req_valid)
    );
endmodule

// File: tb/tb_fp_reg_stack.sv
module tb_fp_reg_stack;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_PUSH = 3'd1, C_STORE = 3'd2, C_SPOP = 3'd3,
                           C_ARITH = 3'd4, C_READ = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [2:0]  op_index = 3'd0;
    logic [79:0] push_data = '0;
    logic        op_ready, rd_valid, overflow, underflow, alu_req_valid;
    logic [79:0] rd_data, alu_opa, alu_opb;
    logic [2:0]  top_ptr;
    logic        alu_res_valid = 1'b0;
    logic [79:0] alu_res_data = '0;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [79:0] VA = 80'h3FFF_8000_0000_0000_0001;
    localparam logic [79:0] VB = 80'h4000_C000_0000_0000_0002;
    localparam logic [79:0] VC = 80'hC001_A000_0000_0000_0003;
    localparam logic [79:0] VR = 80'h4001_F000_0000_0000_00AA;

    fp_reg_stack dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_index(op_index), .push_data(push_data), .op_ready(op_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .overflow(overflow),
        .underflow(underflow), .top_ptr(top_ptr), .alu_req_valid(alu_req_valid),
        .alu_opa(alu_opa), .alu_opb(alu_opb), .alu_res_valid(alu_res_valid),
        .alu_res_data(alu_res_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, accepted at posedge, sample at following negedge
    task automatic do_op(input logic [2:0] code, input logic [2:0] idx, input logic [79:0] data);
        @(negedge clk);
        op_valid  = 1'b1;
        op_code   = code;
        op_index  = idx;
        push_data = data;
        @(negedge clk);
        op_valid  = 1'b0;
        op_code   = 3'd0;
    endtask

    task automatic t_reset;
        check("R1 top_ptr", 80'(top_ptr), 80'd0);
        check("R1 op_ready", 80'(op_ready), 80'd1);
        check("R1 flags", 80'({rd_valid, overflow, underflow, alu_req_valid}), 80'd0);
        do_op(C_STORE, 3'd0, '0);
        check("R1 empty at reset -> underflow", 80'(underflow), 80'd1);
    endtask

    task automatic t_push_read;
        do_op(C_PUSH, 3'd0, VA);
        check("R2 top after first push", 80'(top_ptr), 80'd7);
        do_op(C_PUSH, 3'd0, VB);
        do_op(C_PUSH, 3'd0, VC);
        check("R2 top after three pushes", 80'(top_ptr), 80'd5);
        do_op(C_READ, 3'd0, '0);
        check("R4 read ST0 valid", 80'(rd_valid), 80'd1);
        check("R4 read ST0", rd_data, VC);
        do_op(C_READ, 3'd2, '0);
        check("R4 read ST2", rd_data, VA);
        check("R4 read leaves top", 80'(top_ptr), 80'd5);
    endtask

    task automatic t_store;
        do_op(C_STORE, 3'd0, '0);
        check("R5 store data", rd_data, VC);
        check("R5 store valid", 80'(rd_valid), 80'd1);
        check("R5 store keeps top", 80'(top_ptr), 80'd5);
        do_op(C_SPOP, 3'd0, '0);
        check("R6 store-pop data", rd_data, VC);
        check("R6 store-pop top", 80'(top_ptr), 80'd6);
        do_op(C_READ, 3'd0, '0);
        check("R6 new ST0", rd_data, VB);
    endtask

    task automatic t_arith;
        do_op(C_ARITH, 3'd0, '0);
        check("R7 request raised", 80'(alu_req_valid), 80'd1);
        check("R7 opa is ST0", alu_opa, VB);
        check("R7 opb is ST1", alu_opb, VA);
        check("R7 op_ready low", 80'(op_ready), 80'd0);
        op_valid = 1'b1; op_code = C_PUSH; push_data = VC;
        repeat (2) @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
        check("R10 push ignored while busy", 80'(top_ptr), 80'd6);
        check("R10 still requesting", 80'(alu_req_valid), 80'd1);
        alu_res_valid = 1'b1; alu_res_data = VR;
        @(negedge clk);
        alu_res_valid = 1'b0;
        check("R8 top after completion", 80'(top_ptr), 80'd7);
        check("R8 request dropped", 80'(alu_req_valid), 80'd0);
        do_op(C_READ, 3'd0, '0);
        check("R8 result is ST0", rd_data, VR);
        do_op(C_READ, 3'd1, '0);
        check("R9 read of empty ST1 underflow", 80'(underflow), 80'd1);
        check("R9 no data on underflow", 80'(rd_valid), 80'd0);
    endtask

    task automatic t_underflow;
        do_op(C_ARITH, 3'd0, '0);
        check("R9 arith one entry underflow", 80'(underflow), 80'd1);
        check("R9 arith not issued", 80'(alu_req_valid), 80'd0);
        check("R9 top unchanged", 80'(top_ptr), 80'd7);
        do_op(C_SPOP, 3'd0, '0);
        check("R6 pop last", rd_data, VR);
        check("R6 top after pop", 80'(top_ptr), 80'd0);
        do_op(C_SPOP, 3'd0, '0);
        check("R9 pop empty underflow", 80'(underflow), 80'd1);
        check("R9 pop empty top", 80'(top_ptr), 80'd0);
    endtask

    task automatic t_overflow_wrap;
        for (int k = 0; k < 8; k++) do_op(C_PUSH, 3'd0, 80'h100 + 80'(k));
        check("R11 top wraps to 0", 80'(top_ptr), 80'd0);
        check("R2 no overflow when filling", 80'(overflow), 80'd0);
        do_op(C_PUSH, 3'd0, VA);
        check("R3 overflow pulse", 80'(overflow), 80'd1);
        check("R3 top unchanged", 80'(top_ptr), 80'd0);
        do_op(C_READ, 3'd7, '0);
        check("R3 bottom entry intact", rd_data, 80'h100);
        do_op(C_READ, 3'd0, '0);
        check("R3 top entry intact", rd_data, 80'h107);
        check("R3 overflow is one cycle", 80'(overflow), 80'd0);
        for (int k = 7; k >= 0; k--) begin
            do_op(C_SPOP, 3'd0, '0);
            check("R11 LIFO order", rd_data, 80'h100 + 80'(k));
        end
        check("R11 top back to 0", 80'(top_ptr), 80'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_read();
        t_store();
        t_arith();
        t_underflow();
        t_overflow_wrap();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule